// File: doc/BRIEF.md
# Character Row Pattern Fetch with Cursor Overlay

This block produces one 5-pixel row of a character cell for a dot-matrix character display. It takes an 8-bit character code and a 3-bit row index and looks up the row in one of two pattern stores. The first is a writable store of 16 user-defined glyphs, used when the top four code bits are all zero. The second is a fixed pattern ROM, used for every other code. Both stores share the single 8-bit code space.

A cursor can be placed on the cell. The underline form ORs a full bar into the last row, row 7. The blink form, during its fill phase, lights every pixel of the cell. The two forms can be enabled together. A host write port loads the user glyph store. The address of an entry is the glyph number (code bits 3..0) in address bits 6..3, followed by the row in address bits 2..0. The output row is registered.

Top module: `glyph_row_fetch`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pix_row` is 0. Reset also clears all 128 user glyph entries to 0.
- R2: When `char_code[7:4]` is not 0, the row comes from the fixed ROM. Its placeholder content for code c and row r is `c[4:0] ^ {r, r[1:0]}`.
- R3: When `char_code[7:4]` is 0, the row comes from the user store entry at address `{char_code[3:0], pat_row}`.
- R4: A write with `wr_en` high stores `wr_data` at `wr_addr`, where bits 6..3 are the glyph number and bits 2..0 are the row. No other entry changes.
- R5: Pixel bit 4 is the leftmost pixel and bit 0 the rightmost. A 1 means the pixel is lit, and stored bits reach `pix_row` unchanged.
- R6: When `cur_here` and `uline_en` are both high and `pat_row` is 7, the row is the pattern ORed with 5'b11111. Other rows are unaffected by the underline.
- R7: The cursor enables have no effect when `cur_here` is low.
- R8: When `cur_here`, `blink_en` and `blink_fill` are all high, every row is 5'b11111. When `blink_fill` is low, the normal pattern, including any underline, is shown.
- R9: `pix_row` reflects the inputs presented one clock earlier. A write becomes visible to a read presented on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_code | input | 8 | Character code of the cell |
| pat_row | input | 3 | Pattern row within the cell (7 = cursor row) |
| cur_here | input | 1 | Cursor is at this cell |
| uline_en | input | 1 | Underline cursor enable |
| blink_en | input | 1 | Blink cursor enable |
| blink_fill | input | 1 | Blink phase: 1 = cell filled |
| wr_en | input | 1 | User glyph store write strobe |
| wr_addr | input | 7 | Write address {glyph[3:0], row[2:0]} |
| wr_data | input | 5 | Row pixels to store |
| pix_row | output | 5 | Registered 5-pixel row, bit 4 leftmost |

## Verification
A wrong entry in the user glyph store shows up only when the matching code and row are read back. The bench therefore reads the written entries and their neighbours one cycle after each write. A fault in the nibble test or in the address concatenation sends a code to the wrong store or to the wrong row, and the bad pixels appear on the very next registered output. Errors in the cursor overlay are limited to cursor cells, so the bench drives row 7 and the other rows, with the cursor present and absent, in both blink phases.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    localparam int CODE_W   = 8;
    localparam int PIX_W    = 5;
    localparam int ROW_W    = 3;
    localparam int GLYPH_W  = 4;
    localparam int UADDR_W  = GLYPH_W + ROW_W;
    localparam int UDEPTH   = 1 << UADDR_W;
    localparam int ROW_LAST = (1 << ROW_W) - 1;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ROW_W-1:0]  row;
    } cell_req_t;

    typedef struct packed {
        logic here;
        logic uline;
        logic blink;
        logic fill;
    } cursor_ctl_t;

    function automatic logic is_user_code(input logic [CODE_W-1:0] c);
        return c[CODE_W-1:GLYPH_W] == '0;
    endfunction

    // Placeholder font: low code bits mixed with the row number
    function automatic pix_t rom_pattern(input logic [CODE_W-1:0] c,
                                         input logic [ROW_W-1:0] r);
        return c[PIX_W-1:0] ^ {r, r[1:0]};
    endfunction
endpackage

// File: rtl/glyph_uram.sv
module glyph_uram
    import glyph_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [UADDR_W-1:0] waddr,
    input  pix_t               wdata,
    input  logic [UADDR_W-1:0] raddr,
    output pix_t               rdata
);
    pix_t mem [UDEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < UDEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R4
    uram_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/glyph_rom.sv
module glyph_rom
    import glyph_pkg::*;
(
    input  cell_req_t req,
    output pix_t      rdata
);
    always_comb begin
        if (is_user_code(req.code)) rdata = '0;
        else                        rdata = rom_pattern(req.code, req.row);
    end
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import glyph_pkg::*;
(
    input  pix_t             base,
    input  logic [ROW_W-1:0] row,
    input  cursor_ctl_t      ctl,
    output pix_t             mixed
);
    logic fill_now, bar_now;

    always_comb begin
        fill_now = ctl.here && ctl.blink && ctl.fill;
        bar_now  = ctl.here && ctl.uline && (row == ROW_W'(ROW_LAST));
        if (fill_now)     mixed = '1;
        else if (bar_now) mixed = base | '1;
        else              mixed = base;
    end
endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
    import glyph_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   char_code,
    input  logic [2:0]   pat_row,
    input  logic         cur_here,
    input  logic         uline_en,
    input  logic         blink_en,
    input  logic         blink_fill,
    input  logic         wr_en,
    input  logic [6:0]   wr_addr,
    input  logic [4:0]   wr_data,
    output logic [4:0]   pix_row
);
    cell_req_t   req;
    cursor_ctl_t ctl;
    pix_t        user_row, rom_row, base_row, mixed_row;

    assign req = '{code: char_code, row: pat_row};
    assign ctl = '{here: cur_here, uline: uline_en, blink: blink_en, fill: blink_fill};

    glyph_uram u_uram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr ({req.code[GLYPH_W-1:0], req.row}),
        .rdata (user_row)
    );

    glyph_rom u_rom (
        .req   (req),
        .rdata (rom_row)
    );

    assign base_row = is_user_code(req.code) ? user_row : rom_row;

    cursor_mix u_mix (
        .base  (base_row),
        .row   (req.row),
        .ctl   (ctl),
        .mixed (mixed_row)
    );

    always_ff @(posedge clk) begin
        if (rst) pix_row <= '0;
        else     pix_row <= mixed_row;
    end

    // R8
    blink_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cur_here && blink_en && blink_fill)) |-> pix_row == 5'h1f);

    // R6
    underline_row_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cur_here && uline_en && pat_row == 3'd7)) |-> pix_row == 5'h1f);

    // R7
    no_cursor_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cur_here)) |-> pix_row == $past(base_row));

    // R2
    rom_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cur_here) && $past(char_code[7:4] != 4'h0))
            |-> pix_row == $past(rom_row));
endmodule

// File: tb/test_glyph_row_fetch.sv
module test_glyph_row_fetch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] char_code = '0;
    logic [2:0] pat_row = '0;
    logic       cur_here = 1'b0, uline_en = 1'b0, blink_en = 1'b0, blink_fill = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic [4:0] pix_row;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [4:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    glyph_row_fetch i_glyph_row_fetch (
        .clk(clk), .rst(rst), .char_code(char_code), .pat_row(pat_row),
        .cur_here(cur_here), .uline_en(uline_en), .blink_en(blink_en),
        .blink_fill(blink_fill), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_row(pix_row)
    );

    function automatic logic [4:0] font(input logic [7:0] c, input logic [2:0] r);
        return c[4:0] ^ {r, r[1:0]};
    endfunction

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_row=%b expected %b", req, act, exp);
        end
    endtask

    // Monitor: one output per clock, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(pix_row, it.exp, it.req);
        end
    end

    task automatic drive(input logic [7:0] c, input logic [2:0] r,
                         input logic here, input logic ul, input logic bl,
                         input logic fl, input logic [4:0] exp, input string req);
        @(negedge clk);
        char_code = c; pat_row = r; cur_here = here;
        uline_en = ul; blink_en = bl; blink_fill = fl;
        sb.push_back('{exp: exp, req: req});
    endtask

    task automatic write_ent(input logic [6:0] a, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #20000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check(pix_row, 5'h00, "R1 reset");
        @(negedge clk);
        rst = 1'b0;
        // first cycle after reset: user store cleared (R1)
        drive(8'h05, 3'd1, 0, 0, 0, 0, 5'h00, "R1 store cleared");
        drive(8'h0F, 3'd7, 0, 0, 0, 0, 5'h00, "R1 store cleared top");
        // ROM lookups (R2)
        drive(8'h41, 3'd0, 0, 0, 0, 0, font(8'h41, 3'd0), "R2 rom 41/0");
        drive(8'h41, 3'd5, 0, 0, 0, 0, font(8'h41, 3'd5), "R2 rom 41/5");
        drive(8'hFF, 3'd3, 0, 0, 0, 0, font(8'hFF, 3'd3), "R2 rom FF/3");
        drive(8'h10, 3'd2, 0, 0, 0, 0, font(8'h10, 3'd2), "R2 rom 10/2");
        // user writes (R4, R5)
        write_ent({4'd3, 3'd2}, 5'b10000);
        write_ent({4'd15, 3'd7}, 5'b00001);
        write_ent({4'd3, 3'd3}, 5'b10101);
        drive(8'h03, 3'd2, 0, 0, 0, 0, 5'b10000, "R5 leftmost pixel");
        drive(8'h0F, 3'd7, 0, 0, 0, 0, 5'b00001, "R3 user glyph 15 row 7");
        drive(8'h03, 3'd3, 0, 0, 0, 0, 5'b10101, "R3 user glyph 3 row 3");
        drive(8'h03, 3'd1, 0, 0, 0, 0, 5'b00000, "R4 neighbour row untouched");
        drive(8'h02, 3'd2, 0, 0, 0, 0, 5'b00000, "R4 neighbour glyph untouched");
        drive(8'h13, 3'd2, 0, 0, 0, 0, font(8'h13, 3'd2), "R2 upper nibble set uses rom");
        // underline (R6, R7)
        drive(8'h03, 3'd7, 1, 1, 0, 0, 5'h1f, "R6 underline user row 7");
        drive(8'h41, 3'd6, 1, 1, 0, 0, font(8'h41, 3'd6), "R6 underline other row");
        drive(8'h41, 3'd7, 0, 1, 1, 1, font(8'h41, 3'd7), "R7 no cursor here");
        drive(8'h0F, 3'd7, 0, 1, 0, 0, 5'b00001, "R7 no cursor user row 7");
        // blink (R8)
        drive(8'h41, 3'd2, 1, 0, 1, 1, 5'h1f, "R8 blink fill");
        drive(8'h03, 3'd2, 1, 0, 1, 0, 5'b10000, "R8 blink normal phase");
        drive(8'h03, 3'd7, 1, 1, 1, 0, 5'h1f, "R8 normal phase keeps underline");
        drive(8'h20, 3'd0, 1, 1, 0, 1, font(8'h20, 3'd0), "R8 fill ignored without blink_en");
        // write then read on next cycle (R9)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {4'd7, 3'd4}; wr_data = 5'b01110;
        char_code = 8'h07; pat_row = 3'd4; cur_here = 0; uline_en = 0; blink_en = 0; blink_fill = 0;
        sb.push_back('{exp: 5'b00000, req: "R9 same-cycle read sees old"});
        @(negedge clk);
        wr_en = 1'b0;
        sb.push_back('{exp: 5'b01110, req: "R9 next-cycle read sees new"});
        @(negedge clk);
        char_code = 8'h41; pat_row = 3'd1;
        sb.push_back('{exp: font(8'h41, 3'd1), req: "R9 one-cycle latency"});
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule